// File: doc/BRIEF.md
# Two-Bit Successive-Cancellation Polar Decoder

This block decodes one polar codeword of length N (a power of two, default 8) by successive cancellation in the log-likelihood domain, using the min-sum rule. A start pulse captures N channel LLRs, given in sign-magnitude form, together with a mask that marks the frozen source positions. The decoder then works through the code tree one operation per clock. Each of the inner stages performs either an f step or a g step. The last stage is replaced by a pair-decision unit, which settles two neighbouring source bits in the same cycle. Because of this, a codeword takes 1.5N-2 cycles, which is 10 cycles for N=8.

The code is taken as x = u·G, where G is the log2(N)-th Kronecker power of the 2×2 lower-triangular all-ones kernel, with no bit-reversal. The g steps need the encoded values of the sub-trees that have already been decided. These come from a partial-sum network with the same XOR structure as the encoder. Only the encoded values of completed left sub-trees are stored, one set for each stage. When decoding finishes, the N decided bits appear together with a one-cycle done pulse. They stay on the output until the next codeword is accepted.

Top module: `polar_sc2_decoder`

## Requirements
- R1: After reset, done is 0 and bits_out is all zeros.
- R2: done rises exactly 1.5N-2 clock edges after the edge that accepts start, which is 10 edges for N=8.
- R3: done is high for a single cycle per codeword, and start is accepted again from that cycle on.
- R4: start is ignored while a codeword is being decoded. Holding it high changes neither the result nor the timing.
- R5: Every position whose bit is 1 in frozen_in (bit i refers to source bit i) is output as 0, whatever the LLRs.
- R6: LLR i occupies llr_in[i*W +: W]. Its top bit is the sign (1 = negative) and the remaining W-1 bits are the magnitude. A positive LLR favours 0. A non-frozen bit is decided as 1 only when its final LLR is strictly negative, so a zero LLR (including negative zero) gives 0.
- R7: bits_out (bit i = source bit u_i) equals the result of a bit-serial min-sum SC decoder for x = u·G. In that decoder, f gives sign(a)·sign(b)·min(|a|,|b|) and g gives b ± a, where the sign is minus when the partial sum is 1.
- R8: llr_in and frozen_in are captured on the accepting edge. Changes to them during decoding have no effect on the result.
- R9: While the decoder is idle and start is low, bits_out holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding; sampled only while idle |
| llr_in | input | N*W | Channel LLRs in sign-magnitude form, LLR i at bits [i*W +: W] |
| frozen_in | input | N | Frozen-position mask, bit i = 1 forces u_i to 0 |
| bits_out | output | N | Decided source bits, bit i = u_i |
| done | output | 1 | One-cycle pulse when bits_out holds a finished codeword |

## Verification
The assertions assume that any W-bit word is a legal LLR, including negative zero. They also assume that start may arrive in any cycle, because start is only acted on while the decoder is idle. The internal width of W+log2(N) bits is chosen so that the sums along the g chain cannot overflow. For that reason the stimulus draws LLR words uniformly over their full range and needs no clipping. The stimulus includes runs in which start is held high through a whole decode, and runs in which the LLR and mask inputs change every cycle after acceptance. The bench keeps its frozen masks within a small fixed set that includes the empty mask and the full mask.

// File: rtl/polar_pkg.sv
package polar_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } dec_phase_e;

   // Base index of stage s (1..log2(n)-1) in the flat per-stage storage.
   // Stage s holds n>>s entries; stages are stacked from stage 1 upward.
   function automatic int stage_base(input int n, input int s);
      return n - (n >> (s - 1));
   endfunction

endpackage

// File: rtl/polar_fg_unit.sv
module polar_fg_unit #(
   parameter int IW = 9
) (
   input  logic signed [IW-1:0] a,
   input  logic signed [IW-1:0] b,
   input  logic                 psum,
   input  logic                 sel_g,
   output logic signed [IW-1:0] y
);

   logic [IW-1:0]        mag_a;
   logic [IW-1:0]        mag_b;
   logic [IW-1:0]        mag_min;
   logic                 neg;
   logic signed [IW-1:0] f_val;
   logic signed [IW-1:0] g_val;

   if (IW < 3) begin : g_bad_width
      $error("polar_fg_unit: IW must be at least 3");
   end

   always_comb begin
      mag_a   = a[IW-1] ? -a : a;
      mag_b   = b[IW-1] ? -b : b;
      mag_min = (mag_a < mag_b) ? mag_a : mag_b;
      neg     = a[IW-1] ^ b[IW-1];
      f_val   = neg ? -$signed(mag_min) : $signed(mag_min);
      g_val   = psum ? (b - a) : (b + a);
      y       = sel_g ? g_val : f_val;
   end

endmodule

// File: rtl/polar_pair_dec.sv
module polar_pair_dec #(
   parameter int IW = 9
) (
   input  logic signed [IW-1:0] a,
   input  logic signed [IW-1:0] b,
   input  logic                 frz_lo,
   input  logic                 frz_hi,
   output logic                 u_lo,
   output logic                 u_hi
);

   localparam logic signed [IW-1:0] ZERO = '0;

   logic signed [IW-1:0] llr_lo;
   logic signed [IW-1:0] llr_hi;

   // first bit of the pair: f step on the two leaf inputs
   polar_fg_unit #(.IW(IW)) u_leaf_f (
      .a     (a),
      .b     (b),
      .psum  (1'b0),
      .sel_g (1'b0),
      .y     (llr_lo)
   );

   assign u_lo = !frz_lo && (llr_lo < ZERO);

   // second bit: g step steered by the first decision, same cycle
   polar_fg_unit #(.IW(IW)) u_leaf_g (
      .a     (a),
      .b     (b),
      .psum  (u_lo),
      .sel_g (1'b1),
      .y     (llr_hi)
   );

   assign u_hi = !frz_hi && (llr_hi < ZERO);

endmodule

// File: rtl/polar_psum_net.sv
module polar_psum_net #(
   parameter int N  = 8,
   parameter int M  = 3,
   parameter int PW = 2
) (
   input  logic [PW-1:0] pair_idx,
   input  logic          u_lo,
   input  logic          u_hi,
   input  logic [N-3:0]  psl_q,
   output logic [N-3:0]  psl_d
);

   import polar_pkg::*;

   logic [N-1:0] cur;
   logic [N-1:0] nxt;
   logic         stored;

   if (PW != M - 1) begin : g_bad_pw
      $error("polar_psum_net: PW must equal M-1");
   end

   // Walk up the tree from the finished pair: a right child folds into
   // its stored left sibling (encoder butterfly), a left child is stored.
   always_comb begin
      psl_d  = psl_q;
      cur    = '0;
      nxt    = '0;
      cur[0] = u_lo ^ u_hi;
      cur[1] = u_hi;
      stored = 1'b0;
      for (int s = M - 1; s >= 1; s--) begin
         if (!stored) begin
            if (!pair_idx[M-1-s]) begin
               for (int j = 0; j < N / 2; j++) begin
                  if (j < (N >> s)) psl_d[stage_base(N, s) + j] = cur[j];
               end
               stored = 1'b1;
            end else begin
               nxt = cur;
               for (int j = 0; j < N / 2; j++) begin
                  if (j < (N >> s)) begin
                     nxt[j]            = psl_q[stage_base(N, s) + j] ^ cur[j];
                     nxt[j + (N >> s)] = cur[j];
                  end
               end
               cur = nxt;
            end
         end
      end
   end

endmodule

// File: rtl/polar_sc2_decoder.sv
module polar_sc2_decoder
   import polar_pkg::*;
#(
   parameter int N = 8,
   parameter int W = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N*W-1:0] llr_in,
   input  logic [N-1:0]   frozen_in,
   output logic [N-1:0]   bits_out,
   output logic           done
);

   localparam int M   = $clog2(N);
   localparam int PW  = M - 1;
   localparam int NP  = N / 2;
   localparam int IW  = W + M;
   localparam int SW  = $clog2(M + 1);
   localparam int LAT = (3 * N) / 2 - 2;
   localparam int LW  = $clog2(LAT + 1);
   localparam logic [SW-1:0] ST_PAIR   = SW'(M);
   localparam logic [SW-1:0] ST_FIRST  = SW'(1);
   localparam logic [PW-1:0] PAIR_LAST = PW'(NP - 1);

   if (N < 4 || (1 << M) != N) begin : g_bad_n
      $error("polar_sc2_decoder: N must be a power of two, at least 4");
   end
   if (W < 2) begin : g_bad_w
      $error("polar_sc2_decoder: W must be at least 2");
   end

   dec_phase_e           ph_q;
   logic [PW-1:0]        pair_q;
   logic [SW-1:0]        st_q;
   logic [N-1:0]         frz_q;
   logic [N-1:0]         bits_q;
   logic                 done_q;
   logic [N-3:0]         psl_q;
   logic [N-3:0]         psl_d;
   logic signed [IW-1:0] ch_d  [N];
   logic signed [IW-1:0] ch_q  [N];
   logic signed [IW-1:0] stg_q [N-2];
   logic signed [IW-1:0] pe_y  [N-2];
   logic                 stg_we[N-2];
   logic                 accept;
   logic                 run;
   logic                 pair_fire;
   logic                 op_g;
   logic [PW-1:0]        pair_nxt;
   logic [SW-1:0]        restart_st;
   logic                 u_lo;
   logic                 u_hi;
   logic [LW-1:0]        lat_q;

   assign accept    = (ph_q == PH_IDLE) && start;
   assign run       = (ph_q == PH_RUN);
   assign pair_fire = run && (st_q == ST_PAIR);
   assign pair_nxt  = pair_q + 1'b1;

   // f or g at the active inner stage follows the pair index bit of that level
   always_comb begin
      op_g = 1'b0;
      for (int s = 1; s < M; s++) begin
         if (st_q == SW'(s)) op_g = pair_q[M-1-s];
      end
   end

   // next pair restarts at the stage of its lowest set index bit
   always_comb begin
      restart_st = ST_FIRST;
      for (int b = PW - 1; b >= 0; b--) begin
         if (pair_nxt[b]) restart_st = SW'(M - 1 - b);
      end
   end

   // sign-magnitude to two's complement, widened for g growth
   for (genvar i = 0; i < N; i++) begin : g_chan
      logic [W-2:0] mag;
      logic         sgn;
      assign mag     = llr_in[i*W +: W-1];
      assign sgn     = llr_in[i*W + W - 1];
      assign ch_d[i] = sgn ? -$signed({{(IW-W+1){1'b0}}, mag})
                           :  $signed({{(IW-W+1){1'b0}}, mag});
   end

   // inner stages: one processing element per output of each stage
   for (genvar s = 1; s < M; s++) begin : g_stage
      localparam int H    = N >> s;
      localparam int BASE = stage_base(N, s);
      for (genvar i = 0; i < H; i++) begin : g_pe
         logic signed [IW-1:0] pa;
         logic signed [IW-1:0] pb;
         logic signed [IW-1:0] py;
         if (s == 1) begin : g_from_chan
            assign pa = ch_q[i];
            assign pb = ch_q[i + H];
         end else begin : g_from_stage
            localparam int PBASE = stage_base(N, s - 1);
            assign pa = stg_q[PBASE + i];
            assign pb = stg_q[PBASE + i + H];
         end
         polar_fg_unit #(.IW(IW)) u_pe (
            .a     (pa),
            .b     (pb),
            .psum  (psl_q[BASE + i]),
            .sel_g (op_g),
            .y     (py)
         );
         assign pe_y[BASE + i]   = py;
         assign stg_we[BASE + i] = run && (st_q == SW'(s));
      end
   end

   polar_pair_dec #(.IW(IW)) u_pair (
      .a      (stg_q[N-4]),
      .b      (stg_q[N-3]),
      .frz_lo (frz_q[{pair_q, 1'b0}]),
      .frz_hi (frz_q[{pair_q, 1'b1}]),
      .u_lo   (u_lo),
      .u_hi   (u_hi)
   );

   polar_psum_net #(.N(N), .M(M), .PW(PW)) u_psum (
      .pair_idx (pair_q),
      .u_lo     (u_lo),
      .u_hi     (u_hi),
      .psl_q    (psl_q),
      .psl_d    (psl_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < N - 2; k++) stg_q[k] <= '0;
         for (int k = 0; k < N; k++) ch_q[k] <= '0;
      end else begin
         for (int k = 0; k < N - 2; k++) begin
            if (stg_we[k]) stg_q[k] <= pe_y[k];
         end
         if (accept) begin
            for (int k = 0; k < N; k++) ch_q[k] <= ch_d[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         pair_q <= '0;
         st_q   <= ST_FIRST;
         frz_q  <= '0;
         bits_q <= '0;
         done_q <= 1'b0;
         psl_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            ph_q   <= PH_RUN;
            pair_q <= '0;
            st_q   <= ST_FIRST;
            frz_q  <= frozen_in;
         end else if (run) begin
            if (pair_fire) begin
               bits_q[{pair_q, 1'b0}] <= u_lo;
               bits_q[{pair_q, 1'b1}] <= u_hi;
               psl_q                  <= psl_d;
               if (pair_q == PAIR_LAST) begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
               end else begin
                  pair_q <= pair_nxt;
                  st_q   <= restart_st;
               end
            end else begin
               st_q <= st_q + 1'b1;
            end
         end
      end
   end

   assign bits_out = bits_q;
   assign done     = done_q;

   // cycles since acceptance, kept for the latency property
   always_ff @(posedge clk) begin
      if (!rst_n)      lat_q <= '0;
      else if (accept) lat_q <= '0;
      else if (run)    lat_q <= lat_q + 1'b1;
   end

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (lat_q == LW'(LAT)));

   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   p_frozen_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ((bits_q & frz_q) == '0));

   p_mask_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(frz_q));

   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> $stable(bits_q));

   p_pair_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_fire && (pair_q != PAIR_LAST)) |=> (pair_q == $past(pair_q) + 1'b1));

   p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !pair_fire) |=> run);

endmodule

// File: tb/polar_sc2_decoder_test.sv
`timescale 1ns/1ps
module polar_sc2_decoder_test;

   localparam int N   = 8;
   localparam int W   = 6;
   localparam int M   = 3;
   localparam int LAT = 10;
   localparam int NV  = 8;

   // each entry: {frozen mask, eight sign-magnitude LLRs}
   localparam logic [N+N*W-1:0] VEC [NV] = '{
      {8'h17, 48'h8a31c459e270},
      {8'h00, 48'h3f0e21a97c44},
      {8'hff, 48'hb6d5107e2a93},
      {8'h01, 48'h5c2e8f31d0a7},
      {8'h0f, 48'he79430b5c168},
      {8'h7f, 48'h1a2b3c4d5e6f},
      {8'h3b, 48'hfedcba987654},
      {8'h17, 48'h0c30c30c30c3}
   };
   localparam logic [N-1:0] MASKS [6] = '{8'h17, 8'h00, 8'h0f, 8'h3b, 8'h01, 8'h7f};

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [N*W-1:0] llr_in = '0;
   logic [N-1:0]   frozen_in = '0;
   logic [N-1:0]   bits_out;
   logic           done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   polar_sc2_decoder #(.N(N), .W(W)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .llr_in    (llr_in),
      .frozen_in (frozen_in),
      .bits_out  (bits_out),
      .done      (done)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int fmin(input int a, input int b);
      int ma = (a < 0) ? -a : a;
      int mb = (b < 0) ? -b : b;
      int mn = (ma < mb) ? ma : mb;
      return ((a < 0) != (b < 0)) ? -mn : mn;
   endfunction

   function automatic logic [N-1:0] enc(input logic [N-1:0] v, input int h);
      logic [N-1:0] r = v;
      for (int step = 1; step < h; step = step * 2) begin
         for (int j = 0; j < h; j++) begin
            if ((j & step) == 0) r[j] = r[j] ^ r[j + step];
         end
      end
      return r;
   endfunction

   // bit-serial min-sum SC, recomputing the tree for every bit
   function automatic logic [N-1:0] ref_decode(input logic [N*W-1:0] llr,
                                               input logic [N-1:0] frz);
      int ch [N];
      int cur [N];
      int nxt [N];
      logic [N-1:0] u = '0;
      for (int i = 0; i < N; i++) begin
         int mag = int'(llr[i*W +: W-1]);
         ch[i] = llr[i*W + W - 1] ? -mag : mag;
      end
      for (int i = 0; i < N; i++) begin
         int len = N;
         cur = ch;
         for (int s = 1; s <= M; s++) begin
            int h = len / 2;
            if (((i >> (M - s)) & 1) == 0) begin
               for (int j = 0; j < h; j++) nxt[j] = fmin(cur[j], cur[j + h]);
            end else begin
               int base = (i >> (M - s + 1)) << (M - s + 1);
               logic [N-1:0] v = enc(u >> base, h);
               for (int j = 0; j < h; j++)
                  nxt[j] = v[j] ? (cur[j + h] - cur[j]) : (cur[j + h] + cur[j]);
            end
            cur = nxt;
            len = h;
         end
         u[i] = !frz[i] && (cur[0] < 0);
      end
      return u;
   endfunction

   task automatic run_case(input logic [N*W-1:0] llr, input logic [N-1:0] frz,
                           input bit hold, input bit scramble, input string tag,
                           output logic [N-1:0] got);
      logic [N-1:0] exp_bits = ref_decode(llr, frz);
      int cnt = 0;
      @(negedge clk);
      llr_in = llr;
      frozen_in = frz;
      start = 1'b1;
      @(negedge clk);
      if (!hold) start = 1'b0;
      while (!done && cnt < 60) begin
         if (scramble) begin
            llr_in = {$urandom, $urandom};
            frozen_in = N'($urandom);
         end
         @(negedge clk);
         cnt++;
      end
      start = 1'b0;
      got = bits_out;
      chk({"R2 latency ", tag}, cnt, LAT);
      chk({"R7 bits vs serial model ", tag}, got, exp_bits);
      chk({"R5 frozen zero ", tag}, got & frz, 0);
      if (hold) chk({"R4 start held ", tag}, got, exp_bits);
      if (scramble) chk({"R8 inputs latched ", tag}, got, exp_bits);
      @(negedge clk);
      chk({"R3 done single ", tag}, done, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] got;
      logic [N*W-1:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset done", done, 0);
      chk("R1 reset bits", bits_out, 0);

      // stimulus table
      for (int k = 0; k < NV; k++) begin
         run_case(VEC[k][N*W-1:0], VEC[k][N+N*W-1:N*W], 1'b0, 1'b0, "table", got);
      end

      // R6: all LLRs -5 imply all-ones codeword, so only u7 = 1
      w = '0;
      for (int i = 0; i < N; i++) w[i*W +: W] = 6'b100101;
      run_case(w, 8'h00, 1'b0, 1'b0, "neg5", got);
      chk("R6 sign bit meaning", got, 8'h80);
      run_case(w, 8'h80, 1'b0, 1'b0, "neg5 frozen7", got);
      chk("R5 frozen overrides LLR", got, 8'h00);

      // R6: negative zero everywhere gives zeros
      w = '0;
      for (int i = 0; i < N; i++) w[i*W +: W] = 6'b100000;
      run_case(w, 8'h00, 1'b0, 1'b0, "negzero", got);
      chk("R6 zero LLR decides 0", got, 8'h00);

      // R4 and R8
      run_case(VEC[0][N*W-1:0], 8'h17, 1'b1, 1'b0, "hold", got);
      run_case(VEC[3][N*W-1:0], 8'h01, 1'b0, 1'b1, "scramble", got);

      // R9: idle outputs hold while inputs move and start stays low
      llr_in = {$urandom, $urandom};
      frozen_in = 8'h5a;
      repeat (5) @(negedge clk);
      chk("R9 bits held while idle", bits_out, got);

      // random codewords
      for (int k = 0; k < 40; k++) begin
         run_case({$urandom, $urandom}, MASKS[k % 6], 1'b0, 1'b0, "random", got);
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule